// File: doc/BRIEF.md
# Burst Flywheel Loop Synchronizer

This block decides whether a burst-mode subscriber loop receiver is locked to the far end's burst timing. A receiver front end, which is outside this block, reports once per expected burst window, nominally at a 4 kHz rate. Each report says whether a correctly formatted burst landed inside that window. A separate strobe reports a burst that arrived outside any predicted window while the receiver is still hunting for timing.

The block applies symmetric hysteresis. Acquisition takes a run of consecutive good windows. Loss takes a run of consecutive empty windows. A single good burst while locked cancels any run of misses. It drives a status bit, a one-cycle change event for the interrupt logic, and a one-cycle request that tells the window generator to re-time itself on a stray burst. While the device is powered down, the block stays out of sync and ignores every report.

Top module: `loop_sync_flywheel`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `in_sync`, `sync_evt` and `realign_req` are all 0.
- R2: While searching and powered up, ACQ_RUN (default 4) consecutive window reports with `win_good`=1 set `in_sync` to 1 on the clock edge that samples the last of them.
- R3: While searching, a window report with `win_good`=0 drops the good-window run to zero, so a full ACQ_RUN further good windows are needed.
- R4: Cycles with `win_tick`=0 and `stray_burst`=0 change neither run count nor any output.
- R5: While in sync, LOSS_RUN (default 4) consecutive window reports with `win_good`=0 clear `in_sync` on the edge that samples the last of them, and the block returns to searching.
- R6: While in sync, one window report with `win_good`=1 resets the run of missed windows to zero.
- R7: While searching, `stray_burst`=1 raises `realign_req` for exactly one cycle, starting with the next edge, and restarts the good run at 1. When `stray_burst` and `win_tick` are high in the same cycle, the stray burst wins and that window report is discarded.
- R8: While in sync, `stray_burst` is ignored. No realign request is raised and the lock is unaffected.
- R9: `sync_evt` is 1 for exactly one cycle, in the same cycle that `in_sync` takes a new value, and is 0 otherwise.
- R10: While `power_up` is 0, `in_sync` is 0 from the next edge onward, with a `sync_evt` if it had been 1. All reports are ignored and both run counts are cleared, so after power returns a full ACQ_RUN good windows are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| power_up | input | 1 | 1 = device activated; 0 = powered down, held out of sync |
| win_tick | input | 1 | One-cycle strobe at the end of each predicted burst window |
| win_good | input | 1 | Qualifies `win_tick`: a correctly formatted burst arrived in the window |
| stray_burst | input | 1 | A valid burst was seen outside any predicted window |
| in_sync | output | 1 | Loop synchronization status |
| sync_evt | output | 1 | One-cycle pulse on every change of `in_sync` |
| realign_req | output | 1 | One-cycle request to re-time the burst window |

## Verification
The bench goes after four corner cases.

- A bad window after three good ones. A design that forgot to clear the good run on a bad window would lock one window early.
- A good window after three misses while locked. A design that did not reset the miss run would drop sync at the next miss.
- A stray burst coinciding with a window tick. A design that counted the window as well as the stray would start the good run at 2 and lock a window early. A design that re-timed while locked would raise a realign request that should not be there.
- Power-down while locked. A design that dropped the change event or kept a partial run count across power-down would show it in the event pulse or in the lock cycle after power returns.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } sync_state_e;

    typedef struct packed {
        logic tick;
        logic good;
        logic stray;
    } win_report_t;

    function automatic int run_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lsf_run_counter.sv
module lsf_run_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic load_one,
    output logic reach
);
    import lsf_pkg::*;

    localparam int CW = run_width(LIMIT);
    localparam logic [CW-1:0] LAST_BEFORE = CW'(LIMIT - 1);
    localparam logic ONE_IS_LIMIT = (LIMIT == 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
        end else if (load_one) begin
            run_q <= CW'(1);
        end else if (inc) begin
            run_q <= run_q + CW'(1);
        end
    end

    always_comb begin
        reach = 1'b0;
        if (!clr) begin
            if (load_one) begin
                reach = ONE_IS_LIMIT;
            end else if (inc && run_q == LAST_BEFORE) begin
                reach = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lsf_state_ctl.sv
module lsf_state_ctl (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 power_up,
    input  logic                 acq_hit,
    input  logic                 loss_hit,
    input  logic                 realign_now,
    output lsf_pkg::sync_state_e state,
    output logic                 sync_evt,
    output logic                 realign_req
);
    import lsf_pkg::*;

    sync_state_e state_q, state_d;
    logic        evt_q, realign_q;

    always_comb begin
        state_d = state_q;
        if (!power_up) begin
            state_d = ST_SEARCH;
        end else begin
            unique case (state_q)
                ST_SEARCH: if (acq_hit)  state_d = ST_LOCKED;
                ST_LOCKED: if (loss_hit) state_d = ST_SEARCH;
                default:                 state_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_SEARCH;
            evt_q     <= 1'b0;
            realign_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            evt_q     <= (state_d != state_q);
            realign_q <= realign_now;
        end
    end

    assign state       = state_q;
    assign sync_evt    = evt_q;
    assign realign_req = realign_q;

endmodule

// File: rtl/loop_sync_flywheel.sv
module loop_sync_flywheel #(
    parameter int ACQ_RUN  = 4,
    parameter int LOSS_RUN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic power_up,
    input  logic win_tick,
    input  logic win_good,
    input  logic stray_burst,
    output logic in_sync,
    output logic sync_evt,
    output logic realign_req
);
    import lsf_pkg::*;

    win_report_t rep;
    sync_state_e state;
    logic searching, locked;
    logic acq_clr, acq_inc, acq_load, acq_hit;
    logic loss_clr, loss_inc, loss_hit;

    assign rep = '{tick: win_tick, good: win_good, stray: stray_burst};

    assign searching = power_up && (state == ST_SEARCH);
    assign locked    = power_up && (state == ST_LOCKED);

    // Acquisition run: a stray burst takes precedence over a window report.
    always_comb begin
        acq_load = searching && rep.stray;
        acq_inc  = searching && !rep.stray && rep.tick && rep.good;
        acq_clr  = !searching || (!rep.stray && rep.tick && !rep.good);
    end

    // Loss run: only windows seen while locked count; strays are ignored.
    always_comb begin
        loss_inc = locked && rep.tick && !rep.good;
        loss_clr = !locked || (rep.tick && rep.good);
    end

    lsf_run_counter #(.LIMIT(ACQ_RUN)) u_acq_run (
        .clk      (clk),
        .rst      (rst),
        .clr      (acq_clr),
        .inc      (acq_inc),
        .load_one (acq_load),
        .reach    (acq_hit)
    );

    lsf_run_counter #(.LIMIT(LOSS_RUN)) u_loss_run (
        .clk      (clk),
        .rst      (rst),
        .clr      (loss_clr),
        .inc      (loss_inc),
        .load_one (1'b0),
        .reach    (loss_hit)
    );

    lsf_state_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .power_up    (power_up),
        .acq_hit     (acq_hit),
        .loss_hit    (loss_hit),
        .realign_now (acq_load),
        .state       (state),
        .sync_evt    (sync_evt),
        .realign_req (realign_req)
    );

    assign in_sync = (state == ST_LOCKED);

endmodule

// File: rtl/lsf_checks.sv
module lsf_checks (
    input logic clk,
    input logic rst,
    input logic power_up,
    input logic win_tick,
    input logic win_good,
    input logic stray_burst,
    input logic in_sync,
    input logic sync_evt,
    input logic realign_req
);

    // R9: every change of the status bit carries an event
    p_evt_on_change_r9: assert property (@(posedge clk) disable iff (rst)
        (in_sync != $past(in_sync)) |-> sync_evt);

    // R9: no event without a change
    p_evt_only_change_r9: assert property (@(posedge clk) disable iff (rst)
        sync_evt |-> (in_sync != $past(in_sync)));

    // R10: powered down means out of sync on the next edge
    p_power_down_r10: assert property (@(posedge clk) disable iff (rst)
        !power_up |=> !in_sync);

    // R7 / R8: a realign request comes only from a stray burst seen while searching
    p_realign_cause_r7: assert property (@(posedge clk) disable iff (rst)
        realign_req |-> ($past(stray_burst) && $past(power_up) && !$past(in_sync)));

    // R8: no realign request while locked
    p_no_realign_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (in_sync && power_up && stray_burst) |=> !realign_req);

    // R2: lock is taken only on a good window or a stray burst
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(power_up && ((win_tick && win_good) || stray_burst)));

    // R5: while powered, lock is lost only on an empty window
    p_fall_cause_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(in_sync) && $past(power_up)) |-> $past(win_tick && !win_good));

    // R4: an idle cycle leaves the status unchanged
    p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (power_up && !win_tick && !stray_burst) |=> $stable(in_sync));

endmodule

bind loop_sync_flywheel lsf_checks u_lsf_checks (
    .clk         (clk),
    .rst         (rst),
    .power_up    (power_up),
    .win_tick    (win_tick),
    .win_good    (win_good),
    .stray_burst (stray_burst),
    .in_sync     (in_sync),
    .sync_evt    (sync_evt),
    .realign_req (realign_req)
);

// File: tb/loop_sync_flywheel_bench.sv
module loop_sync_flywheel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ACQ  = 4;
    localparam int LOSS = 4;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic power_up = 1'b0;
    logic win_tick = 1'b0;
    logic win_good = 1'b0;
    logic stray_burst = 1'b0;
    logic in_sync, sync_evt, realign_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    int  m_good = 0;
    int  m_miss = 0;
    bit  m_sync = 0;
    bit  m_evt = 0;
    bit  m_realign = 0;

    loop_sync_flywheel #(.ACQ_RUN(ACQ), .LOSS_RUN(LOSS)) u_loop_sync_flywheel (
        .clk         (clk),
        .rst         (rst),
        .power_up    (power_up),
        .win_tick    (win_tick),
        .win_good    (win_good),
        .stray_burst (stray_burst),
        .in_sync     (in_sync),
        .sync_evt    (sync_evt),
        .realign_req (realign_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit prev;
        cycles++;
        prev = m_sync;
        m_realign = 0;
        if (rst) begin
            m_sync = 0; m_good = 0; m_miss = 0; prev = 0;
        end else if (!power_up) begin
            m_sync = 0; m_good = 0; m_miss = 0;
        end else if (!m_sync) begin
            if (stray_burst) begin
                m_realign = 1;
                m_good = 1;
                if (m_good >= ACQ) begin m_sync = 1; m_good = 0; end
            end else if (win_tick) begin
                if (win_good) begin
                    m_good++;
                    if (m_good >= ACQ) begin m_sync = 1; m_good = 0; end
                end else begin
                    m_good = 0;
                end
            end
        end else begin
            if (win_tick) begin
                if (win_good) m_miss = 0;
                else begin
                    m_miss++;
                    if (m_miss >= LOSS) begin m_sync = 0; m_miss = 0; end
                end
            end
        end
        m_evt = (prev != m_sync);
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    // compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, "in_sync model",     in_sync,     m_sync);
            chk(cur_req, "sync_evt model",    sync_evt,    m_evt);
            chk(cur_req, "realign_req model", realign_req, m_realign);
        end
    end

    // drive one cycle of inputs, then wait until outputs reflect them
    task automatic step(input bit pu, input bit t, input bit g, input bit s);
        power_up = pu; win_tick = t; win_good = g; stray_burst = s;
        @(negedge clk);
        win_tick = 0; win_good = 0; stray_burst = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        while (cycles < WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG_CYCLES);
        finish_run();
    end

    initial begin
        int lfsr;
        @(negedge clk); @(negedge clk);
        chk("R1", "in_sync in reset", in_sync, 0);
        chk("R1", "sync_evt in reset", sync_evt, 0);
        chk("R1", "realign_req in reset", realign_req, 0);
        rst = 0;
        step(1, 0, 0, 0);
        chk("R1", "in_sync after reset", in_sync, 0);

        // R2 + R4: four good windows with idle gaps
        cur_req = "R2";
        for (int i = 0; i < ACQ - 1; i++) begin
            step(1, 1, 1, 0);
            idle(3);
            chk("R4", "no lock during run", in_sync, 0);
        end
        step(1, 1, 1, 0);
        chk("R2", "lock after fourth good", in_sync, 1);
        chk("R9", "event on lock", sync_evt, 1);
        idle(1);
        chk("R9", "event one cycle only", sync_evt, 0);

        // R6: misses interrupted by one good window
        cur_req = "R6";
        for (int i = 0; i < LOSS - 1; i++) step(1, 1, 0, 0);
        step(1, 1, 1, 0);
        for (int i = 0; i < LOSS - 1; i++) begin step(1, 1, 0, 0); idle(2); end
        chk("R6", "still locked after reset miss run", in_sync, 1);

        // R8: stray while locked ignored
        cur_req = "R8";
        step(1, 0, 0, 1);
        chk("R8", "no realign when locked", realign_req, 0);
        chk("R8", "lock kept on stray", in_sync, 1);

        // R5: the fourth consecutive miss drops lock
        cur_req = "R5";
        step(1, 1, 0, 0);
        chk("R5", "lock lost on fourth miss", in_sync, 0);
        chk("R9", "event on loss", sync_evt, 1);

        // R3: a bad window restarts acquisition
        cur_req = "R3";
        step(1, 1, 1, 0); step(1, 1, 1, 0); step(1, 1, 1, 0);
        step(1, 1, 0, 0);
        step(1, 1, 1, 0); step(1, 1, 1, 0); step(1, 1, 1, 0);
        chk("R3", "no lock after three good post-bad", in_sync, 0);
        step(1, 1, 1, 0);
        chk("R3", "lock on fourth good post-bad", in_sync, 1);

        // drop lock again
        cur_req = "R5";
        for (int i = 0; i < LOSS; i++) step(1, 1, 0, 0);
        chk("R5", "lock lost again", in_sync, 0);

        // R7: stray with simultaneous tick, then three good windows
        cur_req = "R7";
        step(1, 1, 1, 0);
        step(1, 1, 1, 1);
        chk("R7", "realign pulse", realign_req, 1);
        idle(1);
        chk("R7", "realign single cycle", realign_req, 0);
        step(1, 1, 1, 0); step(1, 1, 1, 0);
        chk("R7", "no lock after stray plus two", in_sync, 0);
        step(1, 1, 1, 0);
        chk("R7", "lock after stray plus three", in_sync, 1);

        // R10: power-down while locked
        cur_req = "R10";
        step(0, 1, 1, 1);
        chk("R10", "out of sync on power down", in_sync, 0);
        chk("R10", "event on power down", sync_evt, 1);
        chk("R10", "no realign when powered down", realign_req, 0);
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0);
        chk("R10", "held out of sync", in_sync, 0);
        step(1, 1, 1, 0); step(1, 1, 1, 0); step(1, 1, 1, 0);
        chk("R10", "fresh run after power up", in_sync, 0);
        step(1, 1, 1, 0);
        chk("R10", "lock after full run", in_sync, 1);

        // mixed pseudo-random traffic against the model
        cur_req = "R9";
        lfsr = 32'h1d2c3b4a;
        for (int i = 0; i < 4000; i++) begin
            bit pu, t, g, s;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pu = (lfsr[7:0] != 8'h00);
            t  = lfsr[9] | lfsr[10];
            g  = (lfsr[13:11] != 3'b000) && (lfsr[15:14] != 2'b00 || !in_sync);
            s  = (lfsr[20:17] == 4'hF);
            step(pu, t, g, s);
        end

        finish_run();
    end

endmodule